// File: doc/BRIEF.md
# Single-Slope PWM Timer with Selectable Period End

This block is a 16-bit up-counter that produces single-slope PWM waveforms on two compare channels, A and B. It advances only on cycles where the timer-tick enable is high. The count climbs to a period end value (TOP) and returns to zero on the following tick. TOP is picked by a 4-bit mode input. It can be one of three fixed widths (8, 9 or 10 bits), the value in a period register, or the live channel-A compare value.

Each channel has a 2-bit output mode that gives a non-inverted waveform, an inverted waveform or a constant low. In PWM modes the compare registers are double-buffered: software writes land in a buffer that is copied to the active value when the count reaches TOP. The period register is not buffered. Writing it below the current count makes the counter miss TOP, run on to 0xFFFF and wrap. Four sticky event flags report overflow, compare A, compare B and period. Software clears a flag by writing 1 to its bit.

There is no streaming data path. Every pin is a plain control or status signal, and all of them are sampled on the rising clock edge.

Top module: `fastpwm_timer`

## Requirements
- R1: TOP is selected by `mode` as follows: 5 gives 0x00FF, 6 gives 0x01FF, 7 gives 0x03FF, 14 gives the period register, 15 gives the active channel-A compare value, and any other code gives 0xFFFF.
- R2: On a cycle with `tick` high, the count returns to 0 if it equals TOP and otherwise increments, wrapping from 0xFFFF to 0. On a cycle with `tick` low, the count holds.
- R3: `flags` bit 0 (overflow) is set after a tick on which the count equals TOP. In mode 14, bit 3 (period) is set on that same tick.
- R4: `flags` bit 1 (A) and bit 2 (B) are set after a tick on which the count equals that channel's active compare value. No match occurs when the active compare value exceeds TOP.
- R5: In modes 5, 6, 7, 14 and 15, a compare write goes into a buffer. The active value takes the buffer contents held before that cycle on the tick where the count equals TOP. In any other mode, a write updates the active value at once.
- R6: In modes 5, 6 and 7, compare write data is masked to 8, 9 and 10 bits respectively before it is stored.
- R7: A period-register write takes effect on the next cycle. If the new value is below the count, the counter runs up to 0xFFFF, wraps to 0, and sets no overflow flag on the way.
- R8: Each channel's internal level goes to 1 on a tick where the count equals TOP. Otherwise it goes to 0 on that channel's match tick. Output mode 2 drives the level, mode 3 drives its inverse, and modes 0 and 1 drive 0.
- R9: Flags are sticky. A 1 in `flag_clr` clears the corresponding bit, and a set event in the same cycle wins over the clear.
- R10: Synchronous reset zeroes the count, the period register, the compare buffers, the active compare values, the levels and the flags.
- R11: In mode 15, the channel-A flag is set on the same tick as the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timer advance enable |
| per_we | input | 1 | Period register write strobe |
| per_wdata | input | 16 | Period register write data |
| cmpa_we | input | 1 | Channel-A compare write strobe |
| cmpa_wdata | input | 16 | Channel-A compare write data |
| cmpb_we | input | 1 | Channel-B compare write strobe |
| cmpb_wdata | input | 16 | Channel-B compare write data |
| mode | input | 4 | TOP selection mode |
| outmode_a | input | 2 | Channel-A output mode |
| outmode_b | input | 2 | Channel-B output mode |
| flag_clr | input | 4 | Write-1-to-clear mask for the flags |
| count | output | 16 | Current counter value |
| flags | output | 4 | Bit 0 overflow, bit 1 A, bit 2 B, bit 3 period |
| pwm_a | output | 1 | Channel-A waveform |
| pwm_b | output | 1 | Channel-B waveform |

## Verification
The assertions check these rules on every cycle:
- the count returns to zero after a TOP tick and holds without a tick;
- a channel's active compare value stays put between TOP ticks in buffered modes;
- the level rises after a TOP tick and falls after a lone match;
- each flag bit is set after its set event and cleared after a clear that has no competing set.

Other behaviours need the bench's scenarios:
- the mode-to-TOP mapping;
- write masking in the fixed modes;
- the long run to 0xFFFF after the period register is lowered below the count;
- the mode-15 pairing of the overflow and A flags;
- the contrast between immediate and buffered compare updates.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  localparam logic [3:0] MODE_FIX8  = 4'd5;
  localparam logic [3:0] MODE_FIX9  = 4'd6;
  localparam logic [3:0] MODE_FIX10 = 4'd7;
  localparam logic [3:0] MODE_PER   = 4'd14;
  localparam logic [3:0] MODE_CMPA  = 4'd15;

  localparam int NCH    = 2;
  localparam int NFLAG  = 4;
  localparam int FL_OVF = 0;
  localparam int FL_CHA = 1;
  localparam int FL_PER = 3;

  function automatic logic buffered_mode(input logic [3:0] m);
    return (m == MODE_FIX8) || (m == MODE_FIX9) || (m == MODE_FIX10) ||
           (m == MODE_PER) || (m == MODE_CMPA);
  endfunction
endpackage

// File: rtl/fpwm_topsel.sv
module fpwm_topsel #(
  parameter int W = 16
) (
  input  logic [3:0]   mode,
  input  logic [W-1:0] per,
  input  logic [W-1:0] cmpa_act,
  output logic [W-1:0] top,
  output logic [W-1:0] wmask
);
  import fpwm_pkg::*;
  localparam logic [W-1:0] TOP8  = {{(W-8){1'b0}}, 8'hFF};
  localparam logic [W-1:0] TOP9  = {{(W-9){1'b0}}, 9'h1FF};
  localparam logic [W-1:0] TOP10 = {{(W-10){1'b0}}, 10'h3FF};
  localparam logic [W-1:0] FULL  = {W{1'b1}};

  always_comb begin
    wmask = FULL;
    case (mode)
      MODE_FIX8:  begin top = TOP8;  wmask = TOP8;  end
      MODE_FIX9:  begin top = TOP9;  wmask = TOP9;  end
      MODE_FIX10: begin top = TOP10; wmask = TOP10; end
      MODE_PER:   top = per;
      MODE_CMPA:  top = cmpa_act;
      default:    top = FULL;
    endcase
  end
endmodule

// File: rtl/fpwm_counter.sv
module fpwm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         hit
);
  logic [W-1:0] cnt_q;

  assign hit = tick && (cnt_q == top);
  assign cnt = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (hit)  cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  // R2
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> (cnt_q == '0));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));
endmodule

// File: rtl/fpwm_channel.sv
module fpwm_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] wmask,
  input  logic         buf_mode,
  input  logic         tick,
  input  logic         hit,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] top,
  input  logic [1:0]   outmode,
  output logic [W-1:0] act,
  output logic         match,
  output logic         wave
);
  logic [W-1:0] buf_q, act_q;
  logic         lvl_q;
  logic [W-1:0] wd;

  assign wd    = wdata & wmask;
  assign act   = act_q;
  assign match = tick && (cnt == act_q) && (act_q <= top);

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (we) buf_q <= wd;
      if (buf_mode) begin
        if (hit) act_q <= buf_q;
      end else if (we) begin
        act_q <= wd;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        lvl_q <= 1'b0;
    else if (hit)   lvl_q <= 1'b1;
    else if (match) lvl_q <= 1'b0;
  end

  always_comb begin
    case (outmode)
      2'd2:    wave = lvl_q;
      2'd3:    wave = ~lvl_q;
      default: wave = 1'b0;
    endcase
  end

  // R5
  act_buffered_chk: assert property (@(posedge clk) disable iff (rst)
    (buf_mode && !hit) |=> $stable(act_q));

  // R8
  lvl_rise_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> lvl_q);

  // R8
  lvl_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (match && !hit) |=> !lvl_q);
endmodule

// File: rtl/fpwm_flags.sv
module fpwm_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] fl_q;
  assign flags = fl_q;

  always_ff @(posedge clk) begin
    if (rst) fl_q <= '0;
    else     fl_q <= (fl_q & ~clr) | set;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> fl_q[i]);
    // R9
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !set[i]) |=> !fl_q[i]);
  end
endmodule

// File: rtl/fastpwm_timer.sv
module fastpwm_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         per_we,
  input  logic [W-1:0] per_wdata,
  input  logic         cmpa_we,
  input  logic [W-1:0] cmpa_wdata,
  input  logic         cmpb_we,
  input  logic [W-1:0] cmpb_wdata,
  input  logic [3:0]   mode,
  input  logic [1:0]   outmode_a,
  input  logic [1:0]   outmode_b,
  input  logic [3:0]   flag_clr,
  output logic [W-1:0] count,
  output logic [3:0]   flags,
  output logic         pwm_a,
  output logic         pwm_b
);
  import fpwm_pkg::*;

  logic [W-1:0] per_q, top, wmask, cnt;
  logic         hit, buf_mode;
  logic         ch_we    [NCH];
  logic [W-1:0] ch_wd    [NCH];
  logic [1:0]   ch_om    [NCH];
  logic [W-1:0] ch_act   [NCH];
  logic [NCH-1:0] ch_match, ch_wave;
  logic [NFLAG-1:0] fset;

  assign ch_we[0] = cmpa_we;  assign ch_wd[0] = cmpa_wdata; assign ch_om[0] = outmode_a;
  assign ch_we[1] = cmpb_we;  assign ch_wd[1] = cmpb_wdata; assign ch_om[1] = outmode_b;
  assign buf_mode = buffered_mode(mode);

  always_ff @(posedge clk) begin
    if (rst)         per_q <= '0;
    else if (per_we) per_q <= per_wdata;
  end

  fpwm_topsel #(.W(W)) u_topsel (
    .mode(mode), .per(per_q), .cmpa_act(ch_act[0]), .top(top), .wmask(wmask)
  );

  fpwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .top(top), .cnt(cnt), .hit(hit)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    fpwm_channel #(.W(W)) u_ch (
      .clk(clk), .rst(rst), .we(ch_we[g]), .wdata(ch_wd[g]), .wmask(wmask),
      .buf_mode(buf_mode), .tick(tick), .hit(hit), .cnt(cnt), .top(top),
      .outmode(ch_om[g]), .act(ch_act[g]), .match(ch_match[g]), .wave(ch_wave[g])
    );
  end

  assign fset[FL_OVF]               = hit;
  assign fset[FL_CHA+NCH-1:FL_CHA]  = ch_match;
  assign fset[FL_PER]               = hit && (mode == MODE_PER);

  fpwm_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set(fset), .clr(flag_clr), .flags(flags)
  );

  assign count = cnt;
  assign pwm_a = ch_wave[0];
  assign pwm_b = ch_wave[1];

  // R11
  cmpa_top_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && mode == MODE_CMPA) |=> (flags[FL_OVF] && flags[FL_CHA]));

  // R3
  per_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && mode == MODE_PER) |=> flags[FL_PER]);
endmodule

// File: tb/sim_fastpwm_timer.sv
`timescale 1ns/1ps
module sim_fastpwm_timer;
  logic clk = 0, rst = 1, tick = 0;
  logic per_we = 0, cmpa_we = 0, cmpb_we = 0;
  logic [15:0] per_wdata = 0, cmpa_wdata = 0, cmpb_wdata = 0;
  logic [3:0] mode = 4'd5, flag_clr = 0;
  logic [1:0] outmode_a = 2'd2, outmode_b = 2'd3;
  logic [15:0] count;
  logic [3:0] flags;
  logic pwm_a, pwm_b;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_cnt, m_per, m_flags;
  int m_buf [2], m_act [2], m_lvl [2];

  always #2 clk = ~clk;

  fastpwm_timer u0 (
    .clk(clk), .rst(rst), .tick(tick), .per_we(per_we), .per_wdata(per_wdata),
    .cmpa_we(cmpa_we), .cmpa_wdata(cmpa_wdata), .cmpb_we(cmpb_we), .cmpb_wdata(cmpb_wdata),
    .mode(mode), .outmode_a(outmode_a), .outmode_b(outmode_b), .flag_clr(flag_clr),
    .count(count), .flags(flags), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  function automatic int f_top(int md, int per, int acta);
    case (md)
      5: return 16'h00FF;  6: return 16'h01FF;  7: return 16'h03FF;
      14: return per;      15: return acta;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic int f_mask(int md);
    case (md)
      5: return 16'h00FF;  6: return 16'h01FF;  7: return 16'h03FF;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic bit f_buf(int md);
    return md == 5 || md == 6 || md == 7 || md == 14 || md == 15;
  endfunction

  function automatic int f_wave(int om, int lvl);
    return (om == 2) ? lvl : (om == 3) ? (1 - lvl) : 0;
  endfunction

  task automatic model_upd();
    int top, hit, wd, nact;
    int mt [2];
    bit we [2];
    int wdi [2];
    if (rst) begin
      m_cnt = 0; m_per = 0; m_flags = 0;
      for (int i = 0; i < 2; i++) begin m_buf[i] = 0; m_act[i] = 0; m_lvl[i] = 0; end
      return;
    end
    top = f_top(mode, m_per, m_act[0]);
    hit = (tick && m_cnt == top) ? 1 : 0;
    we[0] = cmpa_we; wdi[0] = cmpa_wdata;
    we[1] = cmpb_we; wdi[1] = cmpb_wdata;
    for (int i = 0; i < 2; i++)
      mt[i] = (tick && m_cnt == m_act[i] && m_act[i] <= top) ? 1 : 0;
    for (int i = 0; i < 2; i++) begin
      wd = wdi[i] & f_mask(mode);
      nact = m_act[i];
      if (f_buf(mode)) begin if (hit) nact = m_buf[i]; end
      else if (we[i]) nact = wd;
      if (we[i]) m_buf[i] = wd;
      m_act[i] = nact;
      if (hit) m_lvl[i] = 1; else if (mt[i]) m_lvl[i] = 0;
    end
    m_flags = (m_flags & ~int'(flag_clr)) |
              hit | (mt[0] << 1) | (mt[1] << 2) | ((hit && mode == 14) ? 8 : 0);
    if (tick) m_cnt = hit ? 0 : ((m_cnt + 1) & 16'hFFFF);
    if (per_we) m_per = per_wdata;
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_upd();
    @(negedge clk);
    chk({tag, " count R2"}, count, m_cnt);
    chk({tag, " flags R9"}, flags, m_flags);
    chk({tag, " pwm_a R8"}, pwm_a, f_wave(outmode_a, m_lvl[0]));
    chk({tag, " pwm_b R8"}, pwm_b, f_wave(outmode_b, m_lvl[1]));
    per_we = 0; cmpa_we = 0; cmpb_we = 0; flag_clr = 0;
  endtask

  task automatic do_reset(int md);
    rst = 1; tick = 0; mode = md[3:0];
    step("R10 reset");
    rst = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL R2 watchdog expired: actual %0d expected below 190000", cyc);
      finish_run();
    end
  end

  initial begin
    int mx;
    void'($urandom(32'h5EED_1234));
    @(negedge clk);
    do_reset(5);
    chk("R10 count after reset", count, 0);
    chk("R10 flags after reset", flags, 0);
    chk("R10 pwm_a after reset", pwm_a, 0);

    // R5 unbuffered in mode 0
    do_reset(0);
    cmpb_we = 1; cmpb_wdata = 16'd5; step("R5 direct");
    tick = 1;
    repeat (8) step("R5 direct");
    chk("R5 direct write matched", flags[2], 1);

    // R5 buffered in mode 5
    do_reset(5);
    cmpb_we = 1; cmpb_wdata = 16'd200; step("R5 buf");
    tick = 1;
    repeat (258) step("R5 buf");
    flag_clr = 4'hF; step("R5 buf");
    cmpb_we = 1; cmpb_wdata = 16'd5; step("R5 buf");
    repeat (20) step("R5 buf");
    chk("R5 buffered write not yet active", flags[2], 0);

    // R6 masking
    do_reset(5);
    outmode_a = 2'd2;
    cmpa_we = 1; cmpa_wdata = 16'h1234; step("R6 mask");
    tick = 1;
    while (count != 16'h00FF) step("R6 mask");
    step("R6 mask");
    while (count != 16'h0040) step("R6 mask");
    chk("R6 masked compare drove pwm_a low", pwm_a, 0);
    chk("R4 compare A flag", flags[1], 1);

    // R1 mode 6 TOP
    do_reset(6);
    tick = 1;
    while (count != 16'h01FF) step("R1 mode6");
    step("R1 mode6");
    chk("R1 mode6 wrap count", count, 0);
    chk("R3 overflow flag", flags[0], 1);

    // R11 mode 15
    do_reset(15);
    cmpa_we = 1; cmpa_wdata = 16'd9; step("R11");
    tick = 1;
    step("R11");
    while (count != 16'd9) step("R11");
    flag_clr = 4'hF; step("R11");
    chk("R11 ovf and A flags, set beats clear R9", flags, 4'b0011);

    // R7 missed TOP
    do_reset(14);
    per_we = 1; per_wdata = 16'd100; step("R7");
    tick = 1;
    while (count != 16'd60) step("R7");
    per_we = 1; per_wdata = 16'd20; step("R7");
    mx = 0;
    while (count != 0) begin
      step("R7");
      if (int'(count) > mx) mx = count;
    end
    chk("R7 ran to 0xFFFF", mx, 16'hFFFF);
    chk("R7 no overflow flag on wrap", flags[0], 0);

    // random phase
    do_reset(5);
    per_we = 1; per_wdata = 16'd17; step("rnd");
    for (int k = 0; k < 40000; k++) begin
      int md_pick [6] = '{5, 6, 14, 15, 14, 15};
      tick = ($urandom % 4) != 0;
      if (m_cnt == 0 && ($urandom % 8) == 0)
        mode = (($urandom % 16) == 0) ? 4'd7 : md_pick[$urandom % 6][3:0];
      if (($urandom % 40) == 0) begin
        cmpa_we = 1;
        cmpa_wdata = (mode <= 7 && ($urandom % 4) == 0) ? 16'($urandom) : 16'(3 + $urandom % 60);
      end
      if (($urandom % 40) == 0) begin
        cmpb_we = 1;
        cmpb_wdata = (mode <= 7 && ($urandom % 4) == 0) ? 16'($urandom) : 16'($urandom % 80);
      end
      if (m_cnt < 3 && ($urandom % 20) == 0) begin
        per_we = 1; per_wdata = 16'(3 + $urandom % 60);
      end
      if (($urandom % 8) == 0) flag_clr = 4'($urandom);
      if (($urandom % 200) == 0) begin
        outmode_a = 2'($urandom); outmode_b = 2'($urandom);
      end
      step("rnd R1/R4/R5");
    end
    finish_run();
  end
endmodule